// File: doc/BRIEF.md
# Pulse-Window Bandwidth Throttle

This block sits in the read-address and write-address paths of a memory bus. It models interfering traffic by splitting time into repeating windows. Each window has an open phase and then a closed phase. A new address request passes downstream only while the gate is open. The block also counts the data words moved on the read-data and write-data channels. Once the per-window word budget is used up, it shuts the gate until the next window begins. The open length, the closed length and the word budget are configuration inputs. The width of one accounting word (64 or 128 bits) is a parameter, and it is set against the data bus width to give the number of words each data beat is worth.

A small phase sequencer holds one of four states:
- `PH_INIT` is the single cycle after reset. It always leaves through a window start.
- `PH_OPEN` lasts `cfg_on_len` cycles. It moves to `PH_SHUT` when the closed length is non-zero. Otherwise it restarts the window.
- `PH_SHUT` lasts `cfg_off_len` cycles and then restarts the window.
- `PH_FREE` is used while both lengths are zero. It restarts the window as soon as either length becomes non-zero.

A window start goes to `PH_FREE` when both lengths are zero, to `PH_OPEN` when the open length is non-zero, and to `PH_SHUT` otherwise. A word meter clears on every window start. An address gate for each channel keeps a request that has been presented but not yet accepted, so valid never drops before its handshake.

Top module: `pwt_throttle`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released (state `PH_INIT`), `m_arvalid`, `m_awvalid`, `s_arready` and `s_awready` are all 0.
- R2: The first cycle after `PH_INIT` is the first cycle of an open phase. An open phase lasts exactly `cfg_on_len` cycles. While it lasts and the budget is not used up, `m_xvalid` follows `s_xvalid` and `s_xready` follows `m_xready`.
- R3: A closed phase follows each open phase and lasts exactly `cfg_off_len` cycles. During it no new request is presented (`m_xvalid`=0, `s_xready`=0). A new window then begins.
- R4: When `cfg_on_len` and `cfg_off_len` are both 0, the gate stays open on every cycle, and `cfg_cap` has no effect.
- R5: When `cfg_on_len`=0 and `cfg_off_len`>0, the gate never opens. When `cfg_off_len`=0 and `cfg_on_len`>0, open phases of `cfg_on_len` cycles follow one another with no gap, and each one is a new window.
- R6: Each cycle with `r_valid`&`r_ready` adds DATA_W/WORD_W words to the meter, and each cycle with `w_valid`&`w_ready` adds the same amount. Both channels in one cycle add twice that amount. The meter clears at every window start, and beats on the clock edge that starts a window are not counted.
- R7: With `cfg_cap`≠0, once the meter reaches `cfg_cap` no new request is presented for the rest of the window. `cfg_cap`=0 means no limit.
- R8: A request that has been presented (`m_xvalid`=1) but not accepted stays presented until `m_xready` is seen, even if the phase closes or the budget runs out. It is released on the cycle after the handshake.
- R9: The read and write address channels share the phase and budget but hand off independently. Addresses pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_on_len | input | LEN_W | Open-phase length in cycles |
| cfg_off_len | input | LEN_W | Closed-phase length in cycles |
| cfg_cap | input | LEN_W | Word budget per window, 0 = no limit |
| s_arvalid | input | 1 | Upstream read request valid |
| s_arready | output | 1 | Upstream read request ready |
| s_araddr | input | ADDR_W | Upstream read address |
| m_arvalid | output | 1 | Downstream read request valid |
| m_arready | input | 1 | Downstream read request ready |
| m_araddr | output | ADDR_W | Downstream read address |
| s_awvalid | input | 1 | Upstream write request valid |
| s_awready | output | 1 | Upstream write request ready |
| s_awaddr | input | ADDR_W | Upstream write address |
| m_awvalid | output | 1 | Downstream write request valid |
| m_awready | input | 1 | Downstream write request ready |
| m_awaddr | output | ADDR_W | Downstream write address |
| r_valid | input | 1 | Read data valid (observed) |
| r_ready | input | 1 | Read data ready (observed) |
| w_valid | input | 1 | Write data valid (observed) |
| w_ready | input | 1 | Write data ready (observed) |

## Verification
Some properties are checked by assertions on every cycle:
- a pending request stays valid until its handshake;
- the gate presents nothing new while it is shut;
- the phase counter advances by one inside a phase;
- the meter only grows within a window and reads zero after each window start;
- `PH_FREE` is only held when both lengths were zero.

The exact phase lengths, the point in a window where the budget cuts the gate, the word value of a beat and the zero-length corner cases can only be shown by the bench's directed scenarios. Each scenario compares the gate pattern, cycle by cycle, against a window model.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    typedef enum logic [1:0] {
        PH_INIT = 2'd0,
        PH_OPEN = 2'd1,
        PH_SHUT = 2'd2,
        PH_FREE = 2'd3
    } phase_e;

    function automatic phase_e window_entry(input logic on_zero, input logic off_zero);
        if (on_zero && off_zero) return PH_FREE;
        if (!on_zero)            return PH_OPEN;
        return PH_SHUT;
    endfunction

endpackage

// File: rtl/pwt_phase_seq.sv
module pwt_phase_seq
    import pwt_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] on_len,
    input  logic [LEN_W-1:0] off_len,
    output phase_e           phase,
    output logic             win_start
);

    logic [LEN_W-1:0] cnt, cnt_nx;
    logic [LEN_W:0]   cnt_inc;
    phase_e           phase_nx;
    logic             on_zero, off_zero, open_end, shut_end;

    assign on_zero  = (on_len == '0);
    assign off_zero = (off_len == '0);
    assign cnt_inc  = {1'b0, cnt} + 1'b1;
    assign open_end = (cnt_inc >= {1'b0, on_len});
    assign shut_end = (cnt_inc >= {1'b0, off_len});

    always_comb begin
        phase_nx  = phase;
        cnt_nx    = cnt;
        win_start = 1'b0;
        unique case (phase)
            PH_INIT: begin
                win_start = 1'b1;
            end
            PH_OPEN: begin
                if (open_end) begin
                    if (!off_zero) begin
                        phase_nx = PH_SHUT;
                        cnt_nx   = '0;
                    end else begin
                        win_start = 1'b1;
                    end
                end else begin
                    cnt_nx = cnt_inc[LEN_W-1:0];
                end
            end
            PH_SHUT: begin
                if (shut_end) win_start = 1'b1;
                else          cnt_nx    = cnt_inc[LEN_W-1:0];
            end
            PH_FREE: begin
                if (!on_zero || !off_zero) win_start = 1'b1;
            end
            default: begin
                win_start = 1'b1;
            end
        endcase
        if (win_start) begin
            phase_nx = window_entry(on_zero, off_zero);
            cnt_nx   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_INIT;
            cnt   <= '0;
        end else begin
            phase <= phase_nx;
            cnt   <= cnt_nx;
        end
    end

    // Inside one open phase the cycle counter steps by exactly one.
    assert_open_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OPEN && $past(phase) == PH_OPEN && !$past(win_start))
            |-> (cnt == $past(cnt) + 1'b1));

    // Inside one closed phase the cycle counter steps by exactly one.
    assert_shut_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SHUT && $past(phase) == PH_SHUT && !$past(win_start))
            |-> (cnt == $past(cnt) + 1'b1));

    // The permanently open state is only held when both lengths were zero.
    assert_free_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FREE) |-> $past(on_len == '0 && off_len == '0));

endmodule

// File: rtl/pwt_word_meter.sv
module pwt_word_meter #(
    parameter int LEN_W  = 16,
    parameter int DATA_W = 128,
    parameter int WORD_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             r_beat,
    input  logic             w_beat,
    input  logic [LEN_W-1:0] cap,
    output logic             capped
);

    localparam int WPB  = (DATA_W / WORD_W > 0) ? DATA_W / WORD_W : 1;
    localparam int WC_W = LEN_W + 2;

    logic [WC_W-1:0] words;
    logic [WC_W-1:0] add;
    logic [WC_W:0]   sum;

    assign add = (r_beat ? WC_W'(WPB) : '0) + (w_beat ? WC_W'(WPB) : '0);
    assign sum = {1'b0, words} + {1'b0, add};

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            words <= '0;
        end else if (sum[WC_W]) begin
            words <= '1;
        end else begin
            words <= sum[WC_W-1:0];
        end
    end

    assign capped = (cap != '0) && (words >= WC_W'(cap));

    // The meter reads zero after each window start.
    assert_meter_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (words == '0));

    // Within a window the meter never decreases.
    assert_meter_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear) |-> (words >= $past(words)));

endmodule

// File: rtl/pwt_addr_gate.sv
module pwt_addr_gate #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allow,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [ADDR_W-1:0] s_addr,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [ADDR_W-1:0] m_addr
);

    logic hold;
    logic pass;

    assign pass    = allow | hold;
    assign m_valid = s_valid & pass;
    assign s_ready = m_ready & pass;
    assign m_addr  = s_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) hold <= 1'b0;
        else        hold <= m_valid & ~m_ready;
    end

    // A presented request stays presented until it is accepted.
    assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && $past(m_valid && !m_ready)) |-> m_valid);

    // A shut gate presents nothing that was not already pending.
    assert_shut_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!allow && !$past(m_valid && !m_ready)) |-> (!m_valid && !s_ready));

endmodule

// File: rtl/pwt_throttle.sv
module pwt_throttle
    import pwt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 128,
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_on_len,
    input  logic [LEN_W-1:0]  cfg_off_len,
    input  logic [LEN_W-1:0]  cfg_cap,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ADDR_W-1:0] m_araddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ADDR_W-1:0] m_awaddr,
    input  logic              r_valid,
    input  logic              r_ready,
    input  logic              w_valid,
    input  logic              w_ready
);

    phase_e phase;
    logic   win_start;
    logic   capped;
    logic   allow;

    pwt_phase_seq #(.LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .on_len    (cfg_on_len),
        .off_len   (cfg_off_len),
        .phase     (phase),
        .win_start (win_start)
    );

    pwt_word_meter #(.LEN_W(LEN_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (win_start),
        .r_beat (r_valid & r_ready),
        .w_beat (w_valid & w_ready),
        .cap    (cfg_cap),
        .capped (capped)
    );

    always_comb begin
        unique case (phase)
            PH_OPEN: allow = ~capped;
            PH_FREE: allow = 1'b1;
            default: allow = 1'b0;
        endcase
    end

    pwt_addr_gate #(.ADDR_W(ADDR_W)) u_ar_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .allow   (allow),
        .s_valid (s_arvalid),
        .s_ready (s_arready),
        .s_addr  (s_araddr),
        .m_valid (m_arvalid),
        .m_ready (m_arready),
        .m_addr  (m_araddr)
    );

    pwt_addr_gate #(.ADDR_W(ADDR_W)) u_aw_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .allow   (allow),
        .s_valid (s_awvalid),
        .s_ready (s_awready),
        .s_addr  (s_awaddr),
        .m_valid (m_awvalid),
        .m_ready (m_awready),
        .m_addr  (m_awaddr)
    );

    // In the permanently open state, every upstream request is presented.
    assert_free_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FREE && s_arvalid) |-> m_arvalid);

    // The first cycle after reset presents nothing on either channel.
    assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INIT) |-> (!m_arvalid && !m_awvalid));

endmodule

// File: tb/pwt_throttle_tb.sv
`timescale 1ns/1ps
module pwt_throttle_tb;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int DATA_W = 128;
    localparam int WORD_W = 64;
    localparam int WPB    = DATA_W / WORD_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LEN_W-1:0]  cfg_on_len = '0, cfg_off_len = '0, cfg_cap = '0;
    logic              s_arvalid = 1'b0, m_arready = 1'b0, s_awvalid = 1'b0, m_awready = 1'b0;
    logic [ADDR_W-1:0] s_araddr = '0, s_awaddr = '0;
    logic              s_arready, m_arvalid, s_awready, m_awvalid;
    logic [ADDR_W-1:0] m_araddr, m_awaddr;
    logic              r_valid = 1'b0, r_ready = 1'b0, w_valid = 1'b0, w_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwt_throttle #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_on_len(cfg_on_len), .cfg_off_len(cfg_off_len), .cfg_cap(cfg_cap),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .r_valid(r_valid), .r_ready(r_ready), .w_valid(w_valid), .w_ready(w_ready)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Holds reset, applies a configuration, releases reset at a falling edge.
    task automatic start(input int on, input int off, input int cap, input logic rb, input logic wb);
        @(negedge clk);
        rst_n       = 1'b0;
        cfg_on_len  = LEN_W'(on);
        cfg_off_len = LEN_W'(off);
        cfg_cap     = LEN_W'(cap);
        r_valid = rb; r_ready = 1'b1; w_valid = wb; w_ready = 1'b1;
        s_arvalid = 1'b1; m_arready = 1'b1; s_awvalid = 1'b1; m_awready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: quiet during reset and in the cycle after release.
    task automatic t_reset();
        start(4, 3, 0, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R1 in reset m_arvalid", m_arvalid, 0);
        check("R1 in reset s_awready", s_awready, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 init m_arvalid", m_arvalid, 0);
        check("R1 init m_awvalid", m_awvalid, 0);
        check("R1 init s_arready", s_arready, 0);
    endtask

    // Compares the gate, cycle by cycle, against a window model.
    task automatic t_pattern(input string req, input int on, input int off, input int cap,
                             input logic rb, input logic wb, input int n);
        int per_cycle;
        int win;
        start(on, off, cap, rb, wb);
        per_cycle = (int'(rb) + int'(wb)) * WPB;
        win = on + off;
        for (int k = 0; k < n; k++) begin
            int  p;
            logic exp;
            @(negedge clk);
            #1;
            if (win == 0) begin
                exp = 1'b1;
            end else begin
                p   = k % win;
                exp = (p < on) && (cap == 0 || p * per_cycle < cap);
            end
            check(req, {m_arvalid, m_awvalid, s_arready, s_awready}, {exp, exp, exp, exp});
        end
    endtask

    // R8 and R9: a pending read request is held while the write channel closes.
    task automatic t_hold();
        start(3, 4, 0, 1'b0, 1'b0);
        m_arready = 1'b0;
        @(negedge clk);
        #1;
        check("R8 presented in open phase", m_arvalid, 1);
        check("R9 write passes in open phase", m_awvalid, 1);
        repeat (5) @(negedge clk);
        #1;
        check("R8 held in closed phase", m_arvalid, 1);
        check("R8 not accepted while downstream busy", s_arready, 0);
        check("R9 write channel shut meanwhile", m_awvalid, 0);
        m_arready = 1'b1;
        #1;
        check("R8 accepted when downstream ready", s_arready, 1);
        @(negedge clk);
        #1;
        check("R8 released after handshake", m_arvalid, 0);
    endtask

    // R9: addresses pass unchanged on both channels.
    task automatic t_addr();
        start(0, 0, 0, 1'b0, 1'b0);
        s_araddr = 32'hDEAD_0040;
        s_awaddr = 32'h1234_5678;
        @(negedge clk);
        #1;
        check("R9 read address", m_araddr, 32'hDEAD_0040);
        check("R9 write address", m_awaddr, 32'h1234_5678);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pattern("R2 R3 open 4 closed 3", 4, 3, 0, 1'b0, 1'b0, 21);
        t_pattern("R4 both zero with cap", 0, 0, 2, 1'b1, 1'b1, 12);
        t_pattern("R5 open length zero", 0, 5, 0, 1'b0, 1'b0, 12);
        t_pattern("R5 closed length zero", 4, 0, 0, 1'b0, 1'b0, 12);
        t_pattern("R6 R7 read beats cap 6", 10, 5, 6, 1'b1, 1'b0, 30);
        t_pattern("R6 R7 both beats cap 6", 10, 2, 6, 1'b1, 1'b1, 24);
        t_pattern("R5 R6 back to back windows cap 4", 4, 0, 4, 1'b1, 1'b0, 16);
        t_pattern("R7 cap zero unlimited", 5, 2, 0, 1'b1, 1'b1, 14);
        t_hold();
        t_addr();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule